// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Odd-Parity Slot

This block sends one byte at a time on an asynchronous serial line. A byte offered on a valid/ready input is accepted when the transmitter is idle. It is then sent as a fixed ten-slot frame: a low start slot, eight payload slots in least-significant-first order, and a high stop slot. Each slot lasts from one baud tick to the next. The baud tick is a one-cycle pulse that comes from a rate generator outside the block. Between frames the line rests high.

A mode input selects the meaning of the last payload slot. With the mode off, that slot carries bit 7 of the byte. With the mode on, it carries a generated odd-parity bit over bits 0 to 6, so the frame length never changes. The mode is captured together with the byte. Changing it during a frame has no effect on that frame.

The input follows valid/ready rules. A byte transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole frame. A producer that holds `wr_valid` high while `wr_ready` is low is stalled, and its byte is not taken until the line is idle again. There is no other back-pressure path.

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is active and after it is released, `txd` is 1, `busy` is 0 and `wr_ready` is 1.
- R2: A byte is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. From the next cycle, `txd` is 0 (the start slot), `busy` is 1 and `wr_ready` is 0.
- R3: While `busy` is 1, `txd` changes only in the cycle after a clock edge on which `baud_tick` was 1. Every slot holds its value for exactly one baud-tick interval.
- R4: With parity off at acceptance, the 1st through 8th baud ticks after acceptance put byte bits 0, 1, …, 7 on `txd` in that order.
- R5: With parity on at acceptance, ticks 1 to 7 put byte bits 0 to 6 on `txd`. Tick 8 puts out a bit chosen so that the number of ones in bits 0 to 6 plus that bit is odd.
- R6: The 9th tick after acceptance puts out a 1 (the stop slot). The 10th tick ends the frame: from the next cycle `busy` is 0 and `wr_ready` is 1, and `txd` stays 1 until the next acceptance.
- R7: Asserting `wr_valid` while `busy` is 1 has no effect on the frame in progress, and no byte is taken.
- R8: `par_en` is sampled only at acceptance. Toggling it during a frame leaves the current frame unchanged.
- R9: `baud_tick` pulses while idle do not change `txd`, `busy` or `wr_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each slot boundary |
| wr_valid | input | 1 | Byte offer valid |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | High when a byte can be accepted (idle) |
| par_en | input | 1 | 1 = last payload slot carries odd parity |
| txd | output | 1 | Serial line, high when idle |
| busy | output | 1 | High from the cycle after acceptance to the end of the stop slot |

## Verification
A wrong slot counter makes the frame too long or too short. This shows at the ports as `busy` falling one tick early or late, on the same tick where the stop slot should end. A corrupt shift register, or a wrong value captured at load, shows as a wrong `txd` level. It appears in the first slot that follows the fault, at most one baud-tick interval later. A stale parity mode is seen only in the eighth payload slot. The bench therefore checks that slot for every frame, and checks it against mid-frame toggling of the mode input.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  function automatic int frame_slots(input int data_w);
    return data_w + 2;
  endfunction
endpackage

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int W = 7
) (
  input  logic [W-1:0] bits_i,
  output logic         odd_bit_o
);
  // Chosen so that ones(bits_i) + odd_bit_o is odd.
  always_comb odd_bit_o = ~(^bits_i);
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int SLOTS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic shift_o,
  output logic busy_o
);
  localparam int CW = $clog2(SLOTS + 1);

  tx_state_e     state_q;
  logic [CW-1:0] slot_q;
  logic          last_slot;

  always_comb begin
    last_slot = (slot_q == CW'(SLOTS - 1));
    shift_o   = (state_q == TX_SEND) && tick_i;
    busy_o    = (state_q == TX_SEND);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      slot_q  <= '0;
    end else begin
      case (state_q)
        TX_IDLE: if (start_i) begin
          state_q <= TX_SEND;
          slot_q  <= '0;
        end
        TX_SEND: if (tick_i) begin
          if (last_slot) begin
            state_q <= TX_IDLE;
            slot_q  <= '0;
          end else begin
            slot_q <= slot_q + CW'(1);
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int SLOTS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SLOTS-1:0] frame_i,
  input  logic             shift_i,
  output logic             line_o
);
  logic [SLOTS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else if (load_i) begin
      sh_q <= frame_i;
    end else if (shift_i) begin
      sh_q <= {1'b1, sh_q[SLOTS-1:1]};
    end
  end

  always_comb line_o = sh_q[0];
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit HAS_PARITY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              par_en,
  output logic              txd,
  output logic              busy
);
  localparam int SLOTS = frame_slots(DATA_W);

  logic              accept;
  logic              shift;
  logic [DATA_W-1:0] payload;
  logic [SLOTS-1:0]  frame;

  generate
    if (HAS_PARITY) begin : g_par
      logic odd_bit;
      sertx_parity #(.W(DATA_W - 1)) u_par (
        .bits_i   (wr_data[DATA_W-2:0]),
        .odd_bit_o(odd_bit)
      );
      always_comb payload = par_en ? {odd_bit, wr_data[DATA_W-2:0]} : wr_data;
    end else begin : g_nopar
      always_comb payload = wr_data;
    end
  endgenerate

  always_comb begin
    wr_ready = ~busy;
    accept   = wr_valid & wr_ready;
    frame    = {1'b1, payload, 1'b0};
  end

  sertx_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(accept),
    .tick_i (baud_tick),
    .shift_o(shift),
    .busy_o (busy)
  );

  sertx_shifter #(.SLOTS(SLOTS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .frame_i(frame),
    .shift_i(shift),
    .line_o (txd)
  );
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic wr_valid,
  input logic wr_ready,
  input logic txd,
  input logic busy
);
  // R2: acceptance opens the start slot
  a_r2_start_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!txd && busy && !wr_ready));

  // R3: no line change without a tick or a load
  a_r3_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !(wr_valid && wr_ready)) |=> $stable(txd));

  // R6: idle line rests high
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R6: the frame ends only on a tick
  a_r6_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> busy);

  // R7: no acceptance while busy
  a_r7_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);
endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .baud_tick(baud_tick),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .txd      (txd),
  .busy     (busy)
);

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready;
  logic       par_en = 1'b0;
  logic       txd;
  logic       busy;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .par_en(par_en), .txd(txd), .busy(busy)
  );

  function automatic logic [9:0] exp_frame(input logic [7:0] d, input logic pe);
    logic top;
    int ones = 0;
    for (int k = 0; k < 7; k++) ones += d[k];
    top = pe ? ((ones % 2) == 0) : d[7];
    return {1'b1, top, d[6:0], 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  // disturb: 0 none, 1 write while busy (R7), 2 toggle par_en (R8)
  task automatic run_frame(input logic [7:0] d, input logic pe, input int disturb);
    logic [9:0] ef;
    ef = exp_frame(d, pe);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; par_en = pe;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R2 start", {29'd0, txd, busy, wr_ready}, {29'd0, 1'b0, 1'b1, 1'b0});
    for (int i = 1; i <= 10; i++) begin
      int gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (disturb == 1) begin wr_valid = 1'b1; wr_data = ~d; end
        if (disturb == 2) par_en = ~par_en;
        chk("R3 hold", {31'd0, txd}, {31'd0, ef[i-1]});
      end
      wr_valid = 1'b0;
      pulse_tick();
      if (i <= 9) begin
        string r;
        if (i == 9) r = "R6 stop";
        else if (disturb == 1) r = "R7 slot";
        else if (disturb == 2) r = "R8 slot";
        else if (i == 8) r = pe ? "R5 parity" : "R4 bit7";
        else r = pe ? "R5 data" : "R4 data";
        chk(r, {31'd0, txd}, {31'd0, ef[i]});
        chk("R6 busy in frame", {31'd0, busy}, 32'd1);
      end
    end
    chk("R6 end", {29'd0, txd, busy, wr_ready}, {29'd0, 1'b1, 1'b0, 1'b1});
    if (disturb == 1) begin
      pulse_tick();
      chk("R7 no second frame", {30'd0, txd, busy}, {30'd0, 1'b1, 1'b0});
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (2) @(negedge clk);
    chk("R1 in reset", {29'd0, txd, busy, wr_ready}, {29'd0, 1'b1, 1'b0, 1'b1});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {29'd0, txd, busy, wr_ready}, {29'd0, 1'b1, 1'b0, 1'b1});

    for (int k = 0; k < 3; k++) begin
      pulse_tick();
      chk("R9 idle tick", {29'd0, txd, busy, wr_ready}, {29'd0, 1'b1, 1'b0, 1'b1});
    end

    run_frame(8'h00, 1'b0, 0);
    run_frame(8'hFF, 1'b0, 0);
    run_frame(8'h00, 1'b1, 0);
    run_frame(8'hFF, 1'b1, 0);
    run_frame(8'h7F, 1'b1, 0);
    run_frame(8'h80, 1'b1, 0);
    run_frame(8'h80, 1'b0, 0);
    run_frame(8'hA5, 1'b0, 1);
    run_frame(8'h3C, 1'b1, 2);
    run_frame(8'hC3, 1'b0, 2);

    for (int k = 0; k < 24; k++) begin
      logic [7:0] rd;
      logic rp;
      int rm;
      rd = 8'($urandom);
      rp = 1'($urandom);
      rm = $urandom_range(0, 2);
      run_frame(rd, rp, rm);
    end

    repeat (4) @(negedge clk);
    chk("R6 idle rest", {30'd0, txd, busy}, {30'd0, 1'b1, 1'b0});
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule